// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block walks a source element index across a vector loop of length VL and stops only on elements whose predicate bit is set. When an instruction begins, a one-cycle `start` pulse makes the block build a 64-bit source predicate mask and latch it. The mask is built from a 3-bit selector code and three 64-bit integer register values presented at the inputs. The block then searches forward one element per clock cycle. When it lands on an enabled element it raises `elem_valid` with that element's index on `step`. It holds there until the core pulses `advance` to say that the element has been executed.

When the step counter reaches VL, the loop is over. The block emits a one-cycle `loop_end` pulse, which tells the core that the program counter may now move on. At the same time the step returns to zero and the block goes idle. While elements remain, `loop_end` stays low, so the core keeps the program counter where it is. The step is one bit wider than the element index, so the value 64 can serve as the exit marker when VL is 64.

Top module: `pred_step_seq`

## Requirements
- R1: After a synchronous active-high reset, `step` is 0 and `busy`, `elem_valid` and `loop_end` are all low.
- R2: In integer mode, a selector code gives this mask: 0 sets all 64 bits; 1 sets only the bit at position `ra_val[5:0]`; 2 is `ra_val`; 3 is `~ra_val`; 4 is `rb_val`; 5 is `~rb_val`; 6 is `rc_val`; 7 is `~rc_val`.
- R3: When `int_mode` is low, every element is enabled whatever the selectors and register values are.
- R4: In integer mode the source mask is decoded from `dst_sel` unless `twin_pred` is high, in which case it is decoded from `src_sel`.
- R5: Each enabled element with index below VL is presented exactly once, in ascending order. While `elem_valid` is high, `step` equals that index and stays steady until `advance`.
- R6: The search tests one element per cycle. From `start`, or from the `advance` that left element p, the next stop at index i (an element, or VL for the exit) becomes visible i-p+1 cycles later, counting p as -1 after `start`.
- R7: The loop ends only after all enabled elements have been presented. `loop_end` is then high for exactly one cycle, with `step` at 0 and `busy` low.
- R8: With VL equal to 0, no element is presented and `loop_end` follows `start` after two cycles.
- R9: VL of 64 covers all mask bits, including index 63. Any VL above 64 is treated as 64.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle in which `loop_end` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new instruction's loop (taken only when idle) |
| advance | input | 1 | Current element executed; move past it |
| vl | input | 7 | Vector length, 0 to 64 |
| int_mode | input | 1 | High selects integer predication |
| twin_pred | input | 1 | Instruction has separate source predicate |
| src_sel | input | 3 | Source predicate selector code |
| dst_sel | input | 3 | Destination predicate selector code |
| ra_val | input | 64 | First predicate register value |
| rb_val | input | 64 | Second predicate register value |
| rc_val | input | 64 | Third predicate register value |
| step | output | 7 | Current source element index |
| busy | output | 1 | Loop in progress |
| elem_valid | output | 1 | `step` names an enabled element ready to execute |
| loop_end | output | 1 | One-cycle pulse: loop finished, PC may advance |

## Verification
The assertions assume that `advance` is pulsed only while `elem_valid` is high. They also assume that the selector codes, register values and VL matter only in the cycle that `start` is accepted, since the mask and length are latched then. The stimulus follows both assumptions. It raises `advance` for exactly one cycle after it sees `elem_valid`, and it changes the configuration only while the block is idle. Random register values are sometimes ANDed together to make sparse masks, so that long skip runs get exercised. VL is drawn mostly from 0 to 64, plus one directed case above 64 that checks the clamp.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    SEL_ALL      = 3'd0,
    SEL_ONEHOT_A = 3'd1,
    SEL_A        = 3'd2,
    SEL_A_INV    = 3'd3,
    SEL_B        = 3'd4,
    SEL_B_INV    = 3'd5,
    SEL_C        = 3'd6,
    SEL_C_INV    = 3'd7
  } pred_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_READY  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pss_mask_decode.sv
module pss_mask_decode #(
  parameter int NELEM = 64
) (
  input  logic [2:0]       sel,
  input  logic [NELEM-1:0] ra_val,
  input  logic [NELEM-1:0] rb_val,
  input  logic [NELEM-1:0] rc_val,
  output logic [NELEM-1:0] mask
);
  import pss_pkg::*;
  localparam int IDX_W = $clog2(NELEM);

  always_comb begin
    case (pred_sel_e'(sel))
      SEL_ALL:      mask = '1;
      SEL_ONEHOT_A: mask = NELEM'(1) << ra_val[IDX_W-1:0];
      SEL_A:        mask = ra_val;
      SEL_A_INV:    mask = ~ra_val;
      SEL_B:        mask = rb_val;
      SEL_B_INV:    mask = ~rb_val;
      SEL_C:        mask = rc_val;
      SEL_C_INV:    mask = ~rc_val;
      default:      mask = '1;
    endcase
  end
endmodule

// File: rtl/pss_mask_select.sv
module pss_mask_select #(
  parameter int NELEM = 64
) (
  input  logic             int_mode,
  input  logic             twin_pred,
  input  logic [2:0]       src_sel,
  input  logic [2:0]       dst_sel,
  input  logic [NELEM-1:0] ra_val,
  input  logic [NELEM-1:0] rb_val,
  input  logic [NELEM-1:0] rc_val,
  output logic [NELEM-1:0] src_mask
);
  logic [NELEM-1:0] dec_mask [2];
  logic [2:0]       sel_in   [2];

  assign sel_in[0] = dst_sel;
  assign sel_in[1] = src_sel;

  // index 0: destination selector, index 1: separate source selector
  for (genvar g = 0; g < 2; g++) begin : g_dec
    pss_mask_decode #(.NELEM(NELEM)) u_dec (
      .sel    (sel_in[g]),
      .ra_val (ra_val),
      .rb_val (rb_val),
      .rc_val (rc_val),
      .mask   (dec_mask[g])
    );
  end

  always_comb begin
    if (!int_mode)     src_mask = '1;
    else if (twin_pred) src_mask = dec_mask[1];
    else               src_mask = dec_mask[0];
  end
endmodule

// File: rtl/pss_step_ctrl.sv
module pss_step_ctrl #(
  parameter int NELEM = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      advance,
  input  logic [$clog2(NELEM):0]    vl,
  input  logic [NELEM-1:0]          src_mask,
  output logic [$clog2(NELEM):0]    step,
  output logic                      busy,
  output logic                      elem_valid,
  output logic                      loop_end
);
  import pss_pkg::*;
  localparam int IDX_W  = $clog2(NELEM);
  localparam int STEP_W = IDX_W + 1;
  localparam logic [STEP_W-1:0] VL_MAX = STEP_W'(NELEM);

  seq_state_e        state;
  logic [NELEM-1:0]  mask_q;
  logic [STEP_W-1:0] vl_q;
  logic [STEP_W-1:0] step_q;
  logic              end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mask_q <= '0;
      vl_q   <= '0;
      step_q <= '0;
      end_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mask_q <= src_mask;
            vl_q   <= (vl > VL_MAX) ? VL_MAX : vl;
            step_q <= '0;
            state  <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (step_q == vl_q) begin
            step_q <= '0;
            end_q  <= 1'b1;
            state  <= ST_IDLE;
          end else if (mask_q[step_q[IDX_W-1:0]]) begin
            state <= ST_READY;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        ST_READY: begin
          if (advance) begin
            step_q <= step_q + STEP_W'(1);
            state  <= ST_SEARCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign step       = step_q;
  assign busy       = (state != ST_IDLE);
  assign elem_valid = (state == ST_READY);
  assign loop_end   = end_q;
endmodule

// File: rtl/pred_step_seq.sv
module pred_step_seq #(
  parameter int NELEM = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   advance,
  input  logic [$clog2(NELEM):0] vl,
  input  logic                   int_mode,
  input  logic                   twin_pred,
  input  logic [2:0]             src_sel,
  input  logic [2:0]             dst_sel,
  input  logic [NELEM-1:0]       ra_val,
  input  logic [NELEM-1:0]       rb_val,
  input  logic [NELEM-1:0]       rc_val,
  output logic [$clog2(NELEM):0] step,
  output logic                   busy,
  output logic                   elem_valid,
  output logic                   loop_end
);
  logic [NELEM-1:0] src_mask;

  pss_mask_select #(.NELEM(NELEM)) u_sel (
    .int_mode  (int_mode),
    .twin_pred (twin_pred),
    .src_sel   (src_sel),
    .dst_sel   (dst_sel),
    .ra_val    (ra_val),
    .rb_val    (rb_val),
    .rc_val    (rc_val),
    .src_mask  (src_mask)
  );

  pss_step_ctrl #(.NELEM(NELEM)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .advance    (advance),
    .vl         (vl),
    .src_mask   (src_mask),
    .step       (step),
    .busy       (busy),
    .elem_valid (elem_valid),
    .loop_end   (loop_end)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int NELEM = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   advance,
  input logic [$clog2(NELEM):0] step,
  input logic                   busy,
  input logic                   elem_valid,
  input logic                   loop_end
);
  localparam int STEP_W = $clog2(NELEM) + 1;

  p_valid_idx_r5: assert property (@(posedge clk) disable iff (rst)
    elem_valid |-> (step < STEP_W'(NELEM)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && !advance) |=> (elem_valid && $stable(step)));

  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && advance) |=> (!elem_valid && busy && step == $past(step) + STEP_W'(1)));

  p_end_state_r7: assert property (@(posedge clk) disable iff (rst)
    loop_end |-> (step == '0 && !busy && !elem_valid));

  p_end_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    loop_end |=> !loop_end);

  p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_valid_busy_r10: assert property (@(posedge clk) disable iff (rst)
    elem_valid |-> busy);
endmodule

bind pred_step_seq pss_checker #(.NELEM(NELEM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .advance    (advance),
  .step       (step),
  .busy       (busy),
  .elem_valid (elem_valid),
  .loop_end   (loop_end)
);

// File: tb/sim_pred_step_seq.sv
`timescale 1ns/1ps
module sim_pred_step_seq;
  localparam int NELEM = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, advance = 1'b0;
  logic [6:0]  vl = '0;
  logic        int_mode = 1'b0, twin_pred = 1'b0;
  logic [2:0]  src_sel = '0, dst_sel = '0;
  logic [63:0] ra_val = '0, rb_val = '0, rc_val = '0;
  logic [6:0]  step;
  logic        busy, elem_valid, loop_end;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pred_step_seq #(.NELEM(NELEM)) u0 (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .vl(vl),
    .int_mode(int_mode), .twin_pred(twin_pred), .src_sel(src_sel),
    .dst_sel(dst_sel), .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val),
    .step(step), .busy(busy), .elem_valid(elem_valid), .loop_end(loop_end)
  );

  function automatic logic [63:0] ref_decode(input logic [2:0] s,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    case (s)
      3'd0: return '1;
      3'd1: return 64'd1 << a[5:0];
      3'd2: return a;
      3'd3: return ~a;
      3'd4: return b;
      3'd5: return ~b;
      3'd6: return c;
      default: return ~c;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; advance = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_instr(input int vl_i, input bit im, input bit tw,
      input logic [2:0] ss, input logic [2:0] ds,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
      input string mtag);
    logic [63:0] m;
    int vle, p, cnt;
    bit bad;
    m   = !im ? '1 : (tw ? ref_decode(ss, a, b, c) : ref_decode(ds, a, b, c));
    vle = (vl_i > 64) ? 64 : vl_i;
    @(negedge clk);
    vl = 7'(vl_i); int_mode = im; twin_pred = tw; src_sel = ss; dst_sel = ds;
    ra_val = a; rb_val = b; rc_val = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1; p = -1; bad = 1'b0;
    check(busy, "R10 busy after start", busy, 1);
    for (int i = 0; i <= vle && !bad; i++) begin
      if (i == vle || m[i]) begin
        while (!(elem_valid || loop_end) && cnt < 300) begin
          @(negedge clk); cnt++;
        end
        if (i < vle) begin
          check(elem_valid && step == 7'(i), {mtag, " R5 element index"}, step, i);
          check(cnt == i - p + 1, "R6 search latency", cnt, i - p + 1);
          if (!elem_valid || step != 7'(i)) bad = 1'b1;
          else begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            cnt = 1; p = i;
          end
        end else begin
          check(loop_end && step == 7'd0 && !busy,
                vle == 0 ? "R8 empty loop end" : "R7 loop end", loop_end, 1);
          check(cnt == i - p + 1, "R6 exit latency", cnt, i - p + 1);
          if (!loop_end) bad = 1'b1;
          else begin
            @(negedge clk);
            check(!loop_end && !busy, "R7 end pulse one cycle", loop_end, 0);
          end
        end
      end
    end
    if (bad) do_reset();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, c;
    void'($urandom(32'd2024));
    do_reset();
    @(negedge clk);
    check(step == 0 && !busy && !elem_valid && !loop_end, "R1 reset state", step, 0);

    // directed corner cases
    run_instr(0, 1'b0, 1'b0, 3'd0, 3'd0, '0, '0, '0, "R8");
    run_instr(64, 1'b0, 1'b0, 3'd2, 3'd2, '0, '0, '0, "R3 R9");
    run_instr(10, 1'b0, 1'b1, 3'd3, 3'd3, '1, '1, '1, "R3");
    run_instr(64, 1'b1, 1'b0, 3'd0, 3'd1, 64'h3F, '0, '0, "R2 R9 unary top");
    run_instr(64, 1'b1, 1'b0, 3'd0, 3'd1, 64'hC5, '0, '0, "R2 unary modulo");
    run_instr(20, 1'b1, 1'b0, 3'd0, 3'd3, '1, '0, '0, "R2 empty mask");
    run_instr(12, 1'b1, 1'b1, 3'd4, 3'd0, '0, 64'h0000_0000_0000_0A05, '0, "R4 twin src");
    run_instr(12, 1'b1, 1'b0, 3'd4, 3'd7, '0, '1, 64'hFFFF_FFFF_FFFF_FF6F, "R4 dst used");
    run_instr(100, 1'b1, 1'b0, 3'd0, 3'd6, '0, '0, 64'h8000_0000_0000_0001, "R9 clamp");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
      if ($urandom % 2) begin
        a = a & {$urandom, $urandom}; b = b & {$urandom, $urandom};
        c = c & {$urandom, $urandom} & {$urandom, $urandom};
      end
      run_instr(int'($urandom % 65), 1'($urandom % 4 != 0), 1'($urandom),
                3'($urandom), 3'($urandom), a, b, c, "R2 R4 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule